// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

An up/down counter that either counts prescaled ticks of the system clock or decodes a two-phase incremental encoder on inputs A and B. A two-bit function field selects the behaviour. Function 0 counts divided clock ticks upward. Function 1 counts both edges of A. Function 2 counts both edges of B. Function 3 counts every edge of both inputs. In each decoder function, the level of the other input sets the counting direction. Both encoder inputs pass through a two-flop synchroniser before edge detection, so they may be fully asynchronous.

The count wraps within a programmable ceiling and emits a one-cycle update pulse on each wrap. The ceiling can be live or buffered until the next update event. Software reaches the block through a synchronous register port with a registered read. It can write the count directly and can force an update event with a strobe. The strobe loads the buffered ceiling and divider and restarts the divider.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count, direction flag and update pulse are 0, the control, divider and ceiling registers read 0, 0 and all ones, and counting is stopped.
- R2: In function 0 with the run bit set, the count rises by one for every DIV+1 clock cycles, where DIV is the divider value last loaded by an update event. Divider writes take effect only at such an event.
- R3: While the run bit is clear, neither the count nor the divider phase moves. Only a direct count write changes the count.
- R4: In function 1 each edge of A moves the count by one: up when A after the edge differs from B, down when they are equal. Edges of B alone never change the count.
- R5: In function 2 each edge of B moves the count by one: up when B after the edge equals A, down when they differ. Edges of A alone never change the count.
- R6: In function 3 a lone edge of A follows the R4 rule and a lone edge of B follows the R5 rule. The sequence AB = 00,10,11,01,00 therefore counts up by four. If both inputs change in the same synchronised cycle, no step is taken.
- R7: The direction flag (control bit 4, also a port) holds 1 after a downward step and 0 after an upward step. Function 0 steps are upward.
- R8: An upward step from a count at or above the effective ceiling gives 0. A downward step from 0 gives the effective ceiling. Each such wrap raises the update pulse for exactly the following cycle.
- R9: With the buffer bit (control bit 1) clear, a ceiling write sets the effective ceiling at once. With it set, the written value becomes effective only at the next update event.
- R10: Writing 1 to bit 0 at address 4 is an update event. It copies the buffered ceiling and divider into their effective copies and restarts the divider phase. It does not change the count and does not raise the update pulse.
- R11: Register addresses are: 0 control (bit 0 run, bit 1 buffer, bits 3:2 function, bit 4 direction, read-only), 1 count, 2 ceiling, 3 divider, 4 event (reads 0). A read returns the addressed register one cycle after the address is presented. A count write wins over any step in the same cycle.
- R12: An encoder input change applied before clock edge k shows in the count after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Registered read data |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction of the last step, 1 = down |
| upd_o | output | 1 | One-cycle pulse on wrap |

## Verification
The assertions take for granted that the encoder inputs change no faster than the synchroniser can follow. They also take for granted that a ceiling write never shares a cycle with a wrap, since the write would otherwise hide the reload. The stimulus holds each new A/B level for four clocks, and it writes the ceiling only while the inputs are quiet or the block is stopped. Simultaneous A/B changes are applied deliberately, but only in function 3, to exercise the rejected transition.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    FN_TICK = 2'd0,
    FN_X2A  = 2'd1,
    FN_X2B  = 2'd2,
    FN_X4   = 2'd3
  } fn_e;

  localparam int unsigned AD_CTRL  = 0;
  localparam int unsigned AD_COUNT = 1;
  localparam int unsigned AD_CEIL  = 2;
  localparam int unsigned AD_DIV   = 3;
  localparam int unsigned AD_EVENT = 4;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_BUF  = 1;
  localparam int unsigned BIT_FN   = 2;
  localparam int unsigned CTRL_W   = 5;
endpackage

// File: rtl/qenc_sync_edge.sv
module qenc_sync_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] edg
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], raw[i]};
    end
    assign lvl[i] = sh[STAGES-1];
    assign edg[i] = sh[STAGES] ^ sh[STAGES-1];
  end
endmodule

// File: rtl/qenc_prescaler.sv
module qenc_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         restart,
  input  logic         reload,
  input  logic [W-1:0] div_in,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] eff_q;

  assign tick = run && !restart && (cnt_q >= eff_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      eff_q <= '0;
    end else begin
      if (restart || reload) cnt_q <= '0;
      else if (run)          cnt_q <= (cnt_q >= eff_q) ? '0 : cnt_q + 1'b1;
      if (restart || reload) eff_q <= div_in;
    end
  end

  p_psc_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= eff_q)
    else $error("divider phase beyond its limit");
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  fn_e        fn,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] lvl,
  input  logic [1:0] edg,
  output logic       step,
  output logic       down
);
  logic same;
  assign same = (lvl[0] == lvl[1]);

  always_comb begin
    step = 1'b0;
    down = 1'b0;
    unique case (fn)
      FN_TICK: begin step = tick;            down = 1'b0;  end
      FN_X2A:  begin step = edg[0];          down = same;  end
      FN_X2B:  begin step = edg[1];          down = !same; end
      FN_X4:   begin step = edg[0] ^ edg[1]; down = edg[0] ? same : !same; end
      default: begin step = 1'b0;            down = 1'b0;  end
    endcase
    step = step && en;
  end
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              enc_a,
  input  logic              enc_b,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic              upd_o
);
  localparam logic [CNT_W-1:0] CEIL_RST = '1;

  logic             run_q, buf_q, dir_q, upd_q;
  fn_e              fn_q;
  logic [CNT_W-1:0] cnt_q, ceil_q, ceil_eff, rd_q;
  logic [DIV_W-1:0] div_q;

  logic [1:0] lvl, edg;
  logic       tick, step, down;
  logic       wr_ctrl, wr_cnt, wr_ceil, wr_div, ug;
  logic       wrap_up, wrap_dn, wrap;
  logic [CTRL_W-1:0] ctrl_view;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(AD_CTRL));
  assign wr_cnt  = wr_en && (wr_addr == ADDR_W'(AD_COUNT));
  assign wr_ceil = wr_en && (wr_addr == ADDR_W'(AD_CEIL));
  assign wr_div  = wr_en && (wr_addr == ADDR_W'(AD_DIV));
  assign ug      = wr_en && (wr_addr == ADDR_W'(AD_EVENT)) && wr_data[0];

  qenc_sync_edge #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({enc_b, enc_a}),
    .lvl (lvl),
    .edg (edg)
  );

  qenc_prescaler #(.W(DIV_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q && (fn_q == FN_TICK)),
    .restart (ug),
    .reload  (wrap || ug),
    .div_in  (div_q),
    .tick    (tick)
  );

  qenc_step_decode u_dec (
    .fn   (fn_q),
    .en   (run_q),
    .tick (tick),
    .lvl  (lvl),
    .edg  (edg),
    .step (step),
    .down (down)
  );

  assign wrap_up = step && !down && (cnt_q >= ceil_eff);
  assign wrap_dn = step &&  down && (cnt_q == '0);
  assign wrap    = (wrap_up || wrap_dn) && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= wrap;
      if (wr_cnt) begin
        cnt_q <= wr_data;
      end else if (step) begin
        dir_q <= down;
        if (wrap_up)      cnt_q <= '0;
        else if (wrap_dn) cnt_q <= ceil_eff;
        else if (down)    cnt_q <= cnt_q - 1'b1;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      buf_q    <= 1'b0;
      fn_q     <= FN_TICK;
      ceil_q   <= CEIL_RST;
      ceil_eff <= CEIL_RST;
      div_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wr_data[BIT_RUN];
        buf_q <= wr_data[BIT_BUF];
        fn_q  <= fn_e'(wr_data[BIT_FN +: 2]);
      end
      if (wr_ceil) ceil_q <= wr_data;
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0];
      if (wr_ceil && !buf_q) ceil_eff <= wr_data;
      else if (wrap || ug)   ceil_eff <= ceil_q;
    end
  end

  assign ctrl_view = {dir_q, fn_q, buf_q, run_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_W'(AD_CTRL):  rd_q <= CNT_W'(ctrl_view);
        ADDR_W'(AD_COUNT): rd_q <= cnt_q;
        ADDR_W'(AD_CEIL):  rd_q <= ceil_q;
        ADDR_W'(AD_DIV):   rd_q <= CNT_W'(div_q);
        default:           rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign count_o = cnt_q;
  assign dir_o   = dir_q;
  assign upd_o   = upd_q;

  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_cnt) |=> $stable(cnt_q))
    else $error("count moved while stopped");

  p_x2a_ignores_b_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && fn_q == FN_X2A && !edg[0] && !wr_cnt) |=> $stable(cnt_q))
    else $error("count moved without an A edge");

  p_x2b_ignores_a_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && fn_q == FN_X2B && !edg[1] && !wr_cnt) |=> $stable(cnt_q))
    else $error("count moved without a B edge");

  p_x4_collision_r6: assert property (@(posedge clk) disable iff (rst)
    (fn_q == FN_X4 && edg[0] && edg[1] && !wr_cnt) |=> $stable(cnt_q))
    else $error("double edge was counted");

  p_tick_dir_up_r7: assert property (@(posedge clk) disable iff (rst)
    (fn_q == FN_TICK && step && !wr_cnt) |=> !dir_q)
    else $error("tick counting flagged downward");

  p_wrap_up_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !dir_q) |-> (cnt_q == '0))
    else $error("upward wrap did not land on zero");

  p_ceil_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (buf_q && !wrap && !ug) |=> $stable(ceil_eff))
    else $error("buffered ceiling changed outside an update event");
endmodule

// File: tb/sim_qenc_timer.sv
module sim_qenc_timer;
  localparam int CW = 16;
  localparam int AW = 3;
  localparam int MAXV = 65535;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          enc_a = 1'b0;
  logic          enc_b = 1'b0;
  logic [CW-1:0] count_o;
  logic          dir_o;
  logic          upd_o;

  int n_chk = 0;
  int n_err = 0;
  int upd_seen = 0;

  always #4 clk = ~clk;

  qenc_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .enc_a(enc_a), .enc_b(enc_b),
    .count_o(count_o), .dir_o(dir_o), .upd_o(upd_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_cnt, m_dir, m_upd, m_run, m_buf, m_fn, m_ceil, m_ceil_eff, m_div, m_div_eff, m_psc, m_rd;
  bit [1:0] hist[$];
  int a_n, b_n, a_o, b_o, ea, eb, step, dn, tick, wc, ug, wrap, nxt_cnt, nxt_ceil_eff;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_dir = 0; m_upd = 0; m_run = 0; m_buf = 0; m_fn = 0;
      m_ceil = MAXV; m_ceil_eff = MAXV; m_div = 0; m_div_eff = 0; m_psc = 0; m_rd = 0;
      hist = {2'b00, 2'b00, 2'b00, 2'b00};
    end else begin
      hist.push_front({enc_b, enc_a});
      a_n = hist[2][0]; b_n = hist[2][1];
      a_o = hist[3][0]; b_o = hist[3][1];
      void'(hist.pop_back());
      ea = (a_n != a_o); eb = (b_n != b_o);
      ug = wr_en && wr_addr == 4 && wr_data[0];
      wc = wr_en && wr_addr == 1;
      tick = m_run && m_fn == 0 && m_psc >= m_div_eff && !ug;
      case (m_fn)
        0: begin step = tick; dn = 0; end
        1: begin step = ea; dn = (a_n == b_n); end
        2: begin step = eb; dn = (a_n != b_n); end
        default: begin step = ea ^ eb; dn = ea ? (a_n == b_n) : (a_n != b_n); end
      endcase
      if (!m_run) step = 0;
      case (rd_addr)
        0: m_rd = m_run + 2 * m_buf + 4 * m_fn + 16 * m_dir;
        1: m_rd = m_cnt;
        2: m_rd = m_ceil;
        3: m_rd = m_div;
        default: m_rd = 0;
      endcase
      wrap = 0;
      nxt_cnt = m_cnt;
      if (wc) nxt_cnt = wr_data;
      else if (step) begin
        m_dir = dn;
        if (!dn) begin
          if (m_cnt >= m_ceil_eff) begin nxt_cnt = 0; wrap = 1; end
          else nxt_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nxt_cnt = m_ceil_eff; wrap = 1; end
          else nxt_cnt = m_cnt - 1;
        end
      end
      m_cnt = nxt_cnt;
      m_upd = wrap;
      if (ug || wrap) m_psc = 0;
      else if (m_run && m_fn == 0) m_psc = (m_psc >= m_div_eff) ? 0 : m_psc + 1;
      if (ug || wrap) m_div_eff = m_div;
      nxt_ceil_eff = m_ceil_eff;
      if (wr_en && wr_addr == 2 && !m_buf) nxt_ceil_eff = wr_data;
      else if (wrap || ug) nxt_ceil_eff = m_ceil;
      m_ceil_eff = nxt_ceil_eff;
      if (wr_en && wr_addr == 0) begin
        m_run = wr_data[0]; m_buf = wr_data[1]; m_fn = wr_data[3:2];
      end
      if (wr_en && wr_addr == 2) m_ceil = wr_data;
      if (wr_en && wr_addr == 3) m_div = wr_data;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(count_o == m_cnt, "R8 model count", count_o, m_cnt);
      chk(dir_o == m_dir, "R7 model direction", dir_o, m_dir);
      chk(upd_o == m_upd, "R8 model update pulse", upd_o, m_upd);
      chk(rd_data == m_rd, "R11 model read data", rd_data, m_rd);
      if (upd_o) upd_seen++;
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic move(input bit a, input bit b);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v, c0, u0_base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(dir_o == 0 && upd_o == 0, "R1 flags", {dir_o, upd_o}, 0);
    rd(2, v); chk(v == MAXV, "R1 ceiling", v, MAXV);
    rd(0, v); chk(v == 0, "R1 control", v, 0);
    rd(3, v); chk(v == 0, "R1 divider", v, 0);

    // R2 divided tick counting
    wr(3, 2); wr(4, 1); wr(1, 0); wr(0, 1);
    repeat (9) @(negedge clk);
    chk(count_o == 3, "R2 divide by three", count_o, 3);

    // R3 freeze
    wr(0, 0);
    c0 = count_o;
    repeat (5) @(negedge clk);
    chk(count_o == c0, "R3 frozen count", count_o, c0);

    // R4 function 1
    wr(1, 10); wr(0, 5);
    for (int k = 0; k < 2; k++) begin
      move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    end
    chk(count_o == 14, "R4 forward", count_o, 14);
    chk(dir_o == 0, "R7 up flag", dir_o, 0);
    move(0, 1); move(1, 1); move(1, 0); move(0, 0);
    chk(count_o == 12, "R4 reverse", count_o, 12);
    chk(dir_o == 1, "R7 down flag", dir_o, 1);

    // R5 function 2
    wr(0, 9);
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    chk(count_o == 14, "R5 forward", count_o, 14);

    // R6 function 3 and rejected double edge
    wr(0, 13);
    move(1, 0); move(1, 1); move(0, 1); move(0, 0);
    chk(count_o == 18, "R6 forward by four", count_o, 18);
    move(1, 1); move(0, 0);
    chk(count_o == 18, "R6 double edge ignored", count_o, 18);

    // R8 wrap both ways
    wr(2, 5); wr(1, 4);
    u0_base = upd_seen;
    move(1, 0);
    move(1, 1);
    chk(count_o == 0, "R8 wrap up", count_o, 0);
    move(1, 0);
    chk(count_o == 5, "R8 wrap down", count_o, 5);
    chk(upd_seen - u0_base == 2, "R8 pulse count", upd_seen - u0_base, 2);

    // R9 buffered ceiling
    wr(0, 15); wr(2, 7);
    move(1, 1);
    chk(count_o == 0, "R9 old ceiling still used", count_o, 0);
    wr(1, 6);
    move(0, 1);
    chk(count_o == 7, "R9 new ceiling after event", count_o, 7);
    move(0, 0);
    chk(count_o == 0, "R9 wrap at new ceiling", count_o, 0);

    // R10 update strobe
    wr(0, 2); wr(2, 3); wr(3, 0); wr(4, 1); wr(1, 0); wr(0, 3);
    repeat (4) @(negedge clk);
    chk(count_o == 0, "R10 strobe loaded ceiling and divider", count_o, 0);

    // R11 register readback
    wr(0, 2);
    rd(0, v); chk(v == 2, "R11 control", v, 2);
    rd(2, v); chk(v == 3, "R11 ceiling", v, 3);
    rd(3, v); chk(v == 0, "R11 divider", v, 0);
    rd(4, v); chk(v == 0, "R11 event reads zero", v, 0);
    rd(1, v); chk(v == count_o, "R11 count", v, count_o);

    // R12 synchroniser latency
    wr(0, 13); wr(1, 0);
    enc_a = 1'b1;
    @(negedge clk); chk(count_o == 0, "R12 edge k", count_o, 0);
    @(negedge clk); chk(count_o == 0, "R12 edge k+1", count_o, 0);
    @(negedge clk); chk(count_o == 1, "R12 edge k+2", count_o, 1);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule